// File: doc/BRIEF.md
# Time-Multiplexed Multi-Waveform Oscillator

This block is one oscillator datapath shared by a set of voice slots. A slot counter visits every slot in turn, one per clock, so each slot is serviced once per frame of `N_SLOTS` clocks. On each visit the slot's phase accumulator advances by its frequency word. The frequency word then changes by a signed sweep amount, which makes the pitch glide linearly. From the accumulated phase the block forms a lookup phase by adding a per-slot offset and, in frequency-modulation mode, a word fetched from a shared external sample memory. A selectable waveform is then built from that lookup phase.

The waveforms are square, sawtooth, a single-sample pulse on accumulator wrap, sine, sine with frequency modulation, and a band-limited sum of up to eight harmonic cosines averaged back to full scale. Sine values come from a quarter-wave table that is computed when the design is elaborated. Per-slot settings live in a small register file that a host writes one field at a time. The output is one signed sample per clock, tagged with the slot it belongs to.

Top module: `osc_tdm_top`

## Requirements
- R1: While the synchronised reset is active, `smp_valid` is 0. The first clock after it releases services slot 0, and the first valid output carries slot 0.
- R2: Slots are serviced in the order 0,1,…,N_SLOTS-1,0,… with one slot per clock. The sample for the slot serviced on one clock edge appears on `smp_*` after the following edge, and `smp_valid` then stays 1.
- R3: On each service the 28-bit phase becomes phase+freq (mod 2^28), and freq becomes freq plus the sign-extended 20-bit sweep (mod 2^28). The carry out of the phase addition is the wrap flag.
- R4: The 20-bit lookup phase equals new_phase[27:8] + offset, mod 2^20, with the FM word added only in wave code 4.
- R5: Wave code 0 (square) gives +32767 when lookup-phase bit 19 is 0 and -32767 when it is 1.
- R6: Wave code 1 (sawtooth) gives lookup-phase bits [19:4] read as a signed 16-bit value.
- R7: Wave code 2 (pulse) gives +32767 on a service whose phase addition wrapped, and 0 otherwise.
- R8: Wave code 3 (sine) gives S(p). Here q=p[19:18], i=p[17:10] (mirrored to 255-i when q is odd), m=round(32767·sin(π/2·(i+0.5)/256)), and S is -m when q≥2, m otherwise.
- R9: During a slot's service clock, `fm_addr` shows that slot's FM address. In wave code 4, the `fm_data` value present on that clock is added into the lookup phase before S.
- R10: Wave code 5 gives the sum of S((k·p + 2^18) mod 2^20) for k=1..n, divided by n with truncation toward zero, where n = harmonic field + 1.
- R11: Wave codes 6 and 7 give a sample of 0.
- R12: Host field codes are 0 freq, 1 sweep, 2 offset, 3 wave, 4 FM address, 5 harmonic field, 6 phase, and 7 no-op. A write is stored at the clock edge. A write to the slot being serviced on that same edge is not seen by that service. For freq and phase, the written value replaces that service's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchroniser |
| host_we | input | 1 | Host write strobe |
| host_slot | input | SLOT_W | Slot addressed by the write |
| host_sel | input | 3 | Field code of the write (see R12) |
| host_data | input | FREQ_W | Write data, low bits used for narrow fields |
| fm_addr | output | FMA_W | Address into the shared sample memory for the slot in service |
| fm_data | input | PH_W | Word read from the shared sample memory at `fm_addr`, same clock |
| smp_valid | output | 1 | Output sample valid |
| smp_slot | output | SLOT_W | Slot the output sample belongs to |
| smp_data | output | OUT_W | Signed output sample |

## Verification
The bound checker watches, on every clock, that output slots follow round-robin order starting at slot 0, that validity never drops once raised, that square and pulse outputs take only their legal levels, that muted codes give zero, and that table-based waveforms never reach the most negative code. Exact sample values depend on accumulated phase, sweep, offsets, FM words and harmonic averaging, so only the bench's cycle-accurate reference model can show them. The same holds for the timing of host writes that coincide with their slot's service, and for the correctness of `fm_addr`.

// File: rtl/osc_pkg.sv
package osc_pkg;

  typedef enum logic [2:0] {
    WAVE_SQUARE  = 3'd0,
    WAVE_SAW     = 3'd1,
    WAVE_PULSE   = 3'd2,
    WAVE_SINE    = 3'd3,
    WAVE_SINE_FM = 3'd4,
    WAVE_COSSUM  = 3'd5,
    WAVE_MUTE_A  = 3'd6,
    WAVE_MUTE_B  = 3'd7
  } wave_e;

  typedef enum logic [2:0] {
    SEL_FREQ   = 3'd0,
    SEL_SWEEP  = 3'd1,
    SEL_OFFSET = 3'd2,
    SEL_WAVE   = 3'd3,
    SEL_FMADDR = 3'd4,
    SEL_HARM   = 3'd5,
    SEL_PHASE  = 3'd6,
    SEL_NOP    = 3'd7
  } reg_sel_e;

  // Quarter-wave sine sample at the midpoint of bin idx, scaled to amp.
  // Evaluated only at elaboration; Taylor series is exact to far below 1 LSB.
  function automatic int quarter_sine(int idx, int depth, int amp);
    real x;
    real term;
    real acc;
    x    = 3.14159265358979323846 / 2.0 * (real'(idx) + 0.5) / real'(depth);
    term = x;
    acc  = x;
    for (int n = 1; n < 12; n++) begin
      term = -term * x * x / real'((2 * n) * (2 * n + 1));
      acc  = acc + term;
    end
    return int'(acc * real'(amp));
  endfunction

endpackage

// File: rtl/osc_sine_rom.sv
module osc_sine_rom #(
  parameter int PH_W   = 20,
  parameter int OUT_W  = 16,
  parameter int TBL_AW = 8
) (
  input  logic [PH_W-1:0]         phase,
  output logic signed [OUT_W-1:0] value
);
  import osc_pkg::*;

  localparam int DEPTH = 1 << TBL_AW;
  localparam int AMP   = (1 << (OUT_W - 1)) - 1;

  logic [OUT_W-2:0]  tbl [DEPTH];
  logic [1:0]        quad;
  logic [TBL_AW-1:0] idx;
  logic [OUT_W-2:0]  mag;

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_tbl
    assign tbl[gi] = (OUT_W - 1)'(quarter_sine(gi, DEPTH, AMP));
  end

  assign quad = phase[PH_W-1 -: 2];
  assign idx  = phase[PH_W-3 -: TBL_AW];

  always_comb begin
    mag   = quad[0] ? tbl[~idx] : tbl[idx];
    value = quad[1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
  end
endmodule

// File: rtl/osc_param_file.sv
module osc_param_file #(
  parameter int N_SLOTS = 8,
  parameter int SLOT_W  = 3,
  parameter int SWEEP_W = 20,
  parameter int PH_W    = 20,
  parameter int FMA_W   = 6,
  parameter int HARM_W  = 3,
  parameter int DATA_W  = 28
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [SLOT_W-1:0]   wr_slot,
  input  osc_pkg::reg_sel_e   wr_sel,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [SLOT_W-1:0]   rd_slot,
  output logic [SWEEP_W-1:0]  rd_sweep,
  output logic [PH_W-1:0]     rd_offset,
  output osc_pkg::wave_e      rd_wave,
  output logic [FMA_W-1:0]    rd_fmaddr,
  output logic [HARM_W-1:0]   rd_harm
);
  import osc_pkg::*;

  logic [SWEEP_W-1:0] sweep_q  [N_SLOTS];
  logic [SWEEP_W-1:0] sweep_d  [N_SLOTS];
  logic [PH_W-1:0]    offset_q [N_SLOTS];
  logic [PH_W-1:0]    offset_d [N_SLOTS];
  logic [2:0]         wave_q   [N_SLOTS];
  logic [2:0]         wave_d   [N_SLOTS];
  logic [FMA_W-1:0]   fmaddr_q [N_SLOTS];
  logic [FMA_W-1:0]   fmaddr_d [N_SLOTS];
  logic [HARM_W-1:0]  harm_q   [N_SLOTS];
  logic [HARM_W-1:0]  harm_d   [N_SLOTS];

  for (genvar gs = 0; gs < N_SLOTS; gs++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_slot == SLOT_W'(gs));

    always_comb begin
      sweep_d[gs]  = sweep_q[gs];
      offset_d[gs] = offset_q[gs];
      wave_d[gs]   = wave_q[gs];
      fmaddr_d[gs] = fmaddr_q[gs];
      harm_d[gs]   = harm_q[gs];
      if (hit) begin
        case (wr_sel)
          SEL_SWEEP:  sweep_d[gs]  = wr_data[SWEEP_W-1:0];
          SEL_OFFSET: offset_d[gs] = wr_data[PH_W-1:0];
          SEL_WAVE:   wave_d[gs]   = wr_data[2:0];
          SEL_FMADDR: fmaddr_d[gs] = wr_data[FMA_W-1:0];
          SEL_HARM:   harm_d[gs]   = wr_data[HARM_W-1:0];
          default: ;
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sweep_q[gs]  <= '0;
        offset_q[gs] <= '0;
        wave_q[gs]   <= '0;
        fmaddr_q[gs] <= '0;
        harm_q[gs]   <= '0;
      end else if (hit) begin
        sweep_q[gs]  <= sweep_d[gs];
        offset_q[gs] <= offset_d[gs];
        wave_q[gs]   <= wave_d[gs];
        fmaddr_q[gs] <= fmaddr_d[gs];
        harm_q[gs]   <= harm_d[gs];
      end
    end
  end

  assign rd_sweep  = sweep_q[rd_slot];
  assign rd_offset = offset_q[rd_slot];
  assign rd_wave   = wave_e'(wave_q[rd_slot]);
  assign rd_fmaddr = fmaddr_q[rd_slot];
  assign rd_harm   = harm_q[rd_slot];
endmodule

// File: rtl/osc_phase_bank.sv
module osc_phase_bank #(
  parameter int N_SLOTS = 8,
  parameter int SLOT_W  = 3,
  parameter int FREQ_W  = 28,
  parameter int SWEEP_W = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                svc_en,
  input  logic [SLOT_W-1:0]   svc_slot,
  input  logic [SWEEP_W-1:0]  svc_sweep,
  input  logic                wr_en,
  input  logic [SLOT_W-1:0]   wr_slot,
  input  osc_pkg::reg_sel_e   wr_sel,
  input  logic [FREQ_W-1:0]   wr_data,
  output logic [FREQ_W-1:0]   phase_next,
  output logic                wrap
);
  import osc_pkg::*;

  localparam int EXT_W = FREQ_W - SWEEP_W;

  logic [FREQ_W-1:0] phase_q [N_SLOTS];
  logic [FREQ_W-1:0] phase_d [N_SLOTS];
  logic [FREQ_W-1:0] freq_q  [N_SLOTS];
  logic [FREQ_W-1:0] freq_d  [N_SLOTS];
  logic [FREQ_W-1:0] cur_phase;
  logic [FREQ_W-1:0] cur_freq;
  logic [FREQ_W-1:0] freq_next;

  always_comb begin
    cur_phase = phase_q[svc_slot];
    cur_freq  = freq_q[svc_slot];
    {wrap, phase_next} = {1'b0, cur_phase} + {1'b0, cur_freq};
    freq_next = cur_freq + {{EXT_W{svc_sweep[SWEEP_W-1]}}, svc_sweep};
  end

  for (genvar gs = 0; gs < N_SLOTS; gs++) begin : g_slot
    logic svc_hit;
    logic host_hit;
    logic en;
    assign svc_hit  = svc_en && (svc_slot == SLOT_W'(gs));
    assign host_hit = wr_en && (wr_slot == SLOT_W'(gs)) &&
                      (wr_sel == SEL_FREQ || wr_sel == SEL_PHASE);
    assign en       = svc_hit || host_hit;

    always_comb begin
      phase_d[gs] = phase_q[gs];
      freq_d[gs]  = freq_q[gs];
      if (svc_hit) begin
        phase_d[gs] = phase_next;
        freq_d[gs]  = freq_next;
      end
      if (host_hit && wr_sel == SEL_FREQ)  freq_d[gs]  = wr_data;
      if (host_hit && wr_sel == SEL_PHASE) phase_d[gs] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        phase_q[gs] <= '0;
        freq_q[gs]  <= '0;
      end else if (en) begin
        phase_q[gs] <= phase_d[gs];
        freq_q[gs]  <= freq_d[gs];
      end
    end
  end
endmodule

// File: rtl/osc_wave_gen.sv
module osc_wave_gen #(
  parameter int PH_W   = 20,
  parameter int OUT_W  = 16,
  parameter int TBL_AW = 8,
  parameter int HARM_W = 3
) (
  input  logic [PH_W-1:0]         phase,
  input  osc_pkg::wave_e          wave,
  input  logic [HARM_W-1:0]       harm,
  input  logic                    wrap,
  output logic signed [OUT_W-1:0] sample
);
  import osc_pkg::*;

  localparam int MAX_H   = 1 << HARM_W;
  localparam int SUM_W   = OUT_W + HARM_W + 1;
  localparam logic signed [OUT_W-1:0] POS_FS = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic signed [OUT_W-1:0] NEG_FS = -POS_FS;
  localparam logic [PH_W-1:0] QUARTER = PH_W'(1) << (PH_W - 2);

  logic signed [OUT_W-1:0] sine_val;
  logic signed [OUT_W-1:0] lane_val [MAX_H];
  logic signed [SUM_W-1:0] cos_acc;
  logic signed [SUM_W-1:0] cos_avg;
  logic [HARM_W:0]         h_cnt;

  osc_sine_rom #(.PH_W(PH_W), .OUT_W(OUT_W), .TBL_AW(TBL_AW)) u_sine (
    .phase (phase),
    .value (sine_val)
  );

  for (genvar gk = 0; gk < MAX_H; gk++) begin : g_harm
    localparam logic [PH_W-1:0] KMUL = PH_W'(gk + 1);
    logic [PH_W-1:0] lane_ph;
    assign lane_ph = phase * KMUL + QUARTER;
    osc_sine_rom #(.PH_W(PH_W), .OUT_W(OUT_W), .TBL_AW(TBL_AW)) u_lane (
      .phase (lane_ph),
      .value (lane_val[gk])
    );
  end

  always_comb begin
    h_cnt   = {1'b0, harm} + 1'b1;
    cos_acc = '0;
    for (int k = 0; k < MAX_H; k++) begin
      if (k < int'(h_cnt))
        cos_acc = cos_acc + {{(SUM_W-OUT_W){lane_val[k][OUT_W-1]}}, lane_val[k]};
    end
    cos_avg = cos_acc / $signed({{(SUM_W-HARM_W-1){1'b0}}, h_cnt});
  end

  always_comb begin
    case (wave)
      WAVE_SQUARE:  sample = phase[PH_W-1] ? NEG_FS : POS_FS;
      WAVE_SAW:     sample = $signed(phase[PH_W-1 -: OUT_W]);
      WAVE_PULSE:   sample = wrap ? POS_FS : '0;
      WAVE_SINE,
      WAVE_SINE_FM: sample = sine_val;
      WAVE_COSSUM:  sample = cos_avg[OUT_W-1:0];
      default:      sample = '0;
    endcase
  end
endmodule

// File: rtl/osc_tdm_top.sv
module osc_tdm_top #(
  parameter int N_SLOTS = 8,
  parameter int FREQ_W  = 28,
  parameter int SWEEP_W = 20,
  parameter int PH_W    = 20,
  parameter int OUT_W   = 16,
  parameter int FMA_W   = 6,
  parameter int HARM_W  = 3,
  parameter int TBL_AW  = 8,
  localparam int SLOT_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    host_we,
  input  logic [SLOT_W-1:0]       host_slot,
  input  logic [2:0]              host_sel,
  input  logic [FREQ_W-1:0]       host_data,
  output logic [FMA_W-1:0]        fm_addr,
  input  logic [PH_W-1:0]         fm_data,
  output logic                    smp_valid,
  output logic [SLOT_W-1:0]       smp_slot,
  output logic signed [OUT_W-1:0] smp_data
);
  import osc_pkg::*;

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(N_SLOTS - 1);

  logic        rst_meta_q;
  logic        rst_sync_n;
  reg_sel_e    sel;

  logic [SLOT_W-1:0]  slot_q, slot_d;
  logic [SWEEP_W-1:0] p_sweep;
  logic [PH_W-1:0]    p_offset;
  wave_e              p_wave;
  logic [HARM_W-1:0]  p_harm;
  logic [FREQ_W-1:0]  phase_next;
  logic               wrap;
  logic [PH_W-1:0]    lookup;

  logic               b_valid_q;
  logic [SLOT_W-1:0]  b_slot_q;
  logic [PH_W-1:0]    b_phase_q;
  logic [2:0]         b_wave_q;
  logic [HARM_W-1:0]  b_harm_q;
  logic               b_wrap_q;
  logic signed [OUT_W-1:0] gen_sample;

  assign sel = reg_sel_e'(host_sel);

  // Reset: asserted asynchronously, released after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // Slot sequencer
  assign slot_d = (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) slot_q <= '0;
    else             slot_q <= slot_d;
  end

  osc_param_file #(
    .N_SLOTS(N_SLOTS), .SLOT_W(SLOT_W), .SWEEP_W(SWEEP_W), .PH_W(PH_W),
    .FMA_W(FMA_W), .HARM_W(HARM_W), .DATA_W(FREQ_W)
  ) u_params (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (host_we),
    .wr_slot   (host_slot),
    .wr_sel    (sel),
    .wr_data   (host_data),
    .rd_slot   (slot_q),
    .rd_sweep  (p_sweep),
    .rd_offset (p_offset),
    .rd_wave   (p_wave),
    .rd_fmaddr (fm_addr),
    .rd_harm   (p_harm)
  );

  osc_phase_bank #(
    .N_SLOTS(N_SLOTS), .SLOT_W(SLOT_W), .FREQ_W(FREQ_W), .SWEEP_W(SWEEP_W)
  ) u_phase (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .svc_en     (1'b1),
    .svc_slot   (slot_q),
    .svc_sweep  (p_sweep),
    .wr_en      (host_we),
    .wr_slot    (host_slot),
    .wr_sel     (sel),
    .wr_data    (host_data),
    .phase_next (phase_next),
    .wrap       (wrap)
  );

  // Lookup phase: accumulator top bits + offset (+ FM word in FM mode)
  always_comb begin
    lookup = phase_next[FREQ_W-1 -: PH_W] + p_offset;
    if (p_wave == WAVE_SINE_FM) lookup = lookup + fm_data;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      b_valid_q <= 1'b0;
      b_slot_q  <= '0;
      b_phase_q <= '0;
      b_wave_q  <= '0;
      b_harm_q  <= '0;
      b_wrap_q  <= 1'b0;
    end else begin
      b_valid_q <= 1'b1;
      b_slot_q  <= slot_q;
      b_phase_q <= lookup;
      b_wave_q  <= p_wave;
      b_harm_q  <= p_harm;
      b_wrap_q  <= wrap;
    end
  end

  osc_wave_gen #(
    .PH_W(PH_W), .OUT_W(OUT_W), .TBL_AW(TBL_AW), .HARM_W(HARM_W)
  ) u_wave (
    .phase  (b_phase_q),
    .wave   (wave_e'(b_wave_q)),
    .harm   (b_harm_q),
    .wrap   (b_wrap_q),
    .sample (gen_sample)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      smp_valid <= 1'b0;
      smp_slot  <= '0;
      smp_data  <= '0;
    end else begin
      smp_valid <= b_valid_q;
      smp_slot  <= b_slot_q;
      smp_data  <= gen_sample;
    end
  end
endmodule

// File: rtl/osc_tdm_checker.sv
module osc_tdm_checker #(
  parameter int N_SLOTS = 8,
  parameter int SLOT_W  = 3,
  parameter int OUT_W   = 16
) (
  input logic              clk,
  input logic              rst_i,
  input logic              b_valid,
  input logic [2:0]        b_wave,
  input logic              smp_valid,
  input logic [SLOT_W-1:0] smp_slot,
  input logic [OUT_W-1:0]  smp_data
);
  localparam logic [OUT_W-1:0] POS_FS = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] NEG_FS = {1'b1, {(OUT_W-2){1'b0}}, 1'b1};
  localparam logic [OUT_W-1:0] MIN_V  = {1'b1, {(OUT_W-1){1'b0}}};
  localparam logic [SLOT_W-1:0] LAST  = SLOT_W'(N_SLOTS - 1);

  assert_first_slot_R1: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(smp_valid) |-> smp_slot == '0);

  assert_valid_sticky_R2: assert property (@(posedge clk) disable iff (!rst_i)
    smp_valid |=> smp_valid);

  assert_slot_order_R2: assert property (@(posedge clk) disable iff (!rst_i)
    smp_valid |=> smp_slot == (($past(smp_slot) == LAST) ? '0 : $past(smp_slot) + 1'b1));

  assert_square_levels_R5: assert property (@(posedge clk) disable iff (!rst_i)
    (b_valid && b_wave == 3'd0) |=> (smp_data == POS_FS || smp_data == NEG_FS));

  assert_pulse_levels_R7: assert property (@(posedge clk) disable iff (!rst_i)
    (b_valid && b_wave == 3'd2) |=> (smp_data == POS_FS || smp_data == '0));

  assert_table_range_R8: assert property (@(posedge clk) disable iff (!rst_i)
    (b_valid && (b_wave == 3'd3 || b_wave == 3'd4 || b_wave == 3'd5)) |=> smp_data != MIN_V);

  assert_mute_zero_R11: assert property (@(posedge clk) disable iff (!rst_i)
    (b_valid && b_wave[2:1] == 2'b11) |=> smp_data == '0);
endmodule

bind osc_tdm_top osc_tdm_checker #(
  .N_SLOTS(N_SLOTS), .SLOT_W(SLOT_W), .OUT_W(OUT_W)
) u_osc_chk (
  .clk       (clk),
  .rst_i     (rst_sync_n),
  .b_valid   (b_valid_q),
  .b_wave    (b_wave_q),
  .smp_valid (smp_valid),
  .smp_slot  (smp_slot),
  .smp_data  (smp_data)
);

// File: tb/tb_osc_tdm_top.sv
`timescale 1ns/1ps
module tb_osc_tdm_top;
  localparam int NS = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        d_we;
  logic [2:0]  d_slot;
  logic [2:0]  d_sel;
  logic [27:0] d_data;
  logic [5:0]  fm_addr;
  logic [19:0] fm_data;
  logic        smp_valid;
  logic [2:0]  smp_slot;
  logic signed [15:0] smp_data;

  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;
  bit done    = 0;
  string cur_tag = "R3 R4";

  logic [19:0] fmem [64];
  assign fm_data = fmem[fm_addr];

  osc_tdm_top dut (
    .clk(clk), .rst_n(rst_n), .host_we(d_we), .host_slot(d_slot),
    .host_sel(d_sel), .host_data(d_data), .fm_addr(fm_addr), .fm_data(fm_data),
    .smp_valid(smp_valid), .smp_slot(smp_slot), .smp_data(smp_data)
  );

  always #2.5 clk = ~clk;

  // Reference model state
  logic [27:0] m_freq [NS];
  logic [27:0] m_phase[NS];
  logic [19:0] m_sweep[NS];
  logic [19:0] m_off  [NS];
  logic [2:0]  m_wave [NS];
  logic [5:0]  m_fma  [NS];
  logic [2:0]  m_harm [NS];
  int          m_ctr;
  bit          mb_valid;
  int          mb_slot;
  logic [19:0] mb_ph;
  logic [2:0]  mb_wave;
  logic [2:0]  mb_harm;
  bit          mb_wrap;
  bit          e_valid;
  int          e_slot;
  int          e_smp;
  logic [2:0]  e_wave;

  function automatic int sine_ref(logic [19:0] p);
    int q = int'(p[19:18]);
    int i = int'(p[17:10]);
    int m;
    if (q % 2 == 1) i = 255 - i;
    m = int'(32767.0 * $sin(3.141592653589793 / 2.0 * (real'(i) + 0.5) / 256.0));
    return (q >= 2) ? -m : m;
  endfunction

  function automatic int wave_ref(logic [2:0] w, logic [19:0] p, logic [2:0] h, bit wr);
    int s = 0;
    int n = int'(h) + 1;
    case (w)
      3'd0: return p[19] ? -32767 : 32767;
      3'd1: return int'($signed(p[19:4]));
      3'd2: return wr ? 32767 : 0;
      3'd3, 3'd4: return sine_ref(p);
      3'd5: begin
        for (int k = 1; k <= n; k++) begin
          logic [19:0] kp = 20'(p * 20'(k)) + 20'h40000;
          s += sine_ref(kp);
        end
        return s / n;
      end
      default: return 0;
    endcase
  endfunction

  task automatic model_edge();
    int s;
    logic [28:0] sum;
    logic [19:0] lk;
    e_valid = mb_valid; e_slot = mb_slot; e_wave = mb_wave;
    e_smp   = wave_ref(mb_wave, mb_ph, mb_harm, mb_wrap);
    s   = m_ctr;
    sum = {1'b0, m_phase[s]} + {1'b0, m_freq[s]};
    lk  = sum[27:8] + m_off[s];
    if (m_wave[s] == 3'd4) lk = lk + fmem[m_fma[s]];
    mb_valid = 1; mb_slot = s; mb_ph = lk; mb_wave = m_wave[s];
    mb_harm = m_harm[s]; mb_wrap = sum[28];
    m_phase[s] = sum[27:0];
    m_freq[s]  = m_freq[s] + {{8{m_sweep[s][19]}}, m_sweep[s]};
    if (d_we) begin
      case (d_sel)
        3'd0: m_freq[d_slot]  = d_data;
        3'd1: m_sweep[d_slot] = d_data[19:0];
        3'd2: m_off[d_slot]   = d_data[19:0];
        3'd3: m_wave[d_slot]  = d_data[2:0];
        3'd4: m_fma[d_slot]   = d_data[5:0];
        3'd5: m_harm[d_slot]  = d_data[2:0];
        3'd6: m_phase[d_slot] = d_data;
        default: ;
      endcase
    end
    m_ctr = (m_ctr + 1) % NS;
  endtask

  task automatic fail_msg(string req, int act, int exp);
    fails++;
    $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
  endtask

  // One clock: inputs already on d_*; check fm_addr before edge, outputs after.
  task automatic step(bit we, int slot, int sel, logic [27:0] data);
    d_we = we; d_slot = 3'(slot); d_sel = 3'(sel); d_data = data;
    #0.5;
    vectors++;
    if (fm_addr !== m_fma[m_ctr]) fail_msg("R9 fm_addr", int'(fm_addr), int'(m_fma[m_ctr]));
    @(posedge clk);
    model_edge();
    @(negedge clk);
    vectors++;
    if (smp_valid !== e_valid) fail_msg("R1 R2 valid", int'(smp_valid), int'(e_valid));
    else if (e_valid) begin
      if (int'(smp_slot) != e_slot) fail_msg("R2 slot", int'(smp_slot), e_slot);
      if (int'(smp_data) != e_smp) begin
        string t;
        case (e_wave)
          3'd0: t = "R5"; 3'd1: t = "R6"; 3'd2: t = "R7"; 3'd3: t = "R8";
          3'd4: t = "R9"; 3'd5: t = "R10"; default: t = "R11";
        endcase
        fail_msg({t, " ", cur_tag, " sample"}, int'(smp_data), e_smp);
      end
    end
    d_we = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 7, '0);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      fail_msg("R2 watchdog", cyc, 100000);
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < 64; i++) fmem[i] = 20'($urandom);
    for (int i = 0; i < NS; i++) begin
      m_freq[i] = 0; m_phase[i] = 0; m_sweep[i] = 0; m_off[i] = 0;
      m_wave[i] = 0; m_fma[i] = 0; m_harm[i] = 0;
    end
    m_ctr = 0; mb_valid = 0; mb_slot = 0; mb_ph = 0; mb_wave = 0; mb_harm = 0; mb_wrap = 0;
    d_we = 0; d_slot = 0; d_sel = 7; d_data = 0;
    rst_n = 1'b1;
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    vectors++;
    if (smp_valid !== 1'b0) fail_msg("R1 reset valid", int'(smp_valid), 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    vectors++;
    if (smp_valid !== 1'b0) fail_msg("R1 sync hold", int'(smp_valid), 0);

    // Directed set-up: one waveform per slot (R5..R11, R12 field codes)
    step(1, 0, 0, 28'h0123456);
    step(1, 1, 3, 28'd1); step(1, 1, 0, 28'h0345678); step(1, 1, 2, 28'h12345);
    step(1, 2, 3, 28'd2); step(1, 2, 0, 28'h4000000);
    step(1, 3, 3, 28'd3); step(1, 3, 0, 28'h00B0000); step(1, 3, 1, 28'h00400);
    step(1, 4, 3, 28'd4); step(1, 4, 4, 28'd17); step(1, 4, 0, 28'h0050000);
    step(1, 5, 3, 28'd5); step(1, 5, 5, 28'd7); step(1, 5, 0, 28'h0021000);
    step(1, 6, 3, 28'd6); step(1, 6, 0, 28'h0777777);
    step(1, 7, 3, 28'd5); step(1, 7, 5, 28'd0); step(1, 7, 0, 28'h0900000);
    step(1, 7, 1, 28'hFFF00);
    idle(200);

    // R12: writes that coincide with the addressed slot's own service
    cur_tag = "R12";
    while (m_ctr != 3) step(0, 0, 7, '0);
    step(1, 3, 2, 28'h40000);
    while (m_ctr != 2) step(0, 0, 7, '0);
    step(1, 2, 6, 28'hFFFFFF0);
    while (m_ctr != 5) step(0, 0, 7, '0);
    step(1, 5, 0, 28'h0001000);
    idle(3 * NS);

    // Constrained random traffic with occasional phase and wave changes
    cur_tag = "R3 R4 random";
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(3) == 0) begin
        int sel = $urandom_range(6);
        logic [27:0] dat = 28'($urandom);
        if (sel == 1) dat = 28'(20'($signed(13'($urandom))));
        step(1, $urandom_range(NS - 1), sel, dat);
      end else begin
        step(0, 0, 7, '0);
      end
    end
    idle(2 * NS);

    done = 1;
    summary();
    $finish;
  end
endmodule